// File: doc/BRIEF.md
# Worn Page Parity Group Matcher

This block sits in the wear-management path of a phase-change main memory controller. Pages that have worn past the point where the per-word ECC can cope are offered to it one at a time, each with its page number and a bitmap of failed bit positions. The block keeps a partial parity group of up to two pages. It admits a new page only if none of that page's failed positions coincide with a failed position of a page already in the group. When the group is complete, it announces the group with the member page numbers. A parity store kept elsewhere can then rebuild any failed bit from the surviving members.

Groups normally hold three pages. A page with more than the shrink threshold of failures makes three-way matching too costly, so any group containing such a page closes at two members. A page at or above the retirement threshold is never grouped: it is reported for permanent retirement. A second input reports fresh wear on pages that are already grouped. If a page in a three-page group crosses the shrink threshold, the block asks for that group to be broken up and re-paired. If a page crosses the retirement threshold, the block retires it. Candidate selection and pool storage belong to the surrounding controller.

Top module: `pg_group_ctrl`

## Requirements
- R1: In the cycle after synchronous reset, all four event pulses (form, retire, reject, disband) are low and no candidate is held, so the next group needs a full complement of fresh members. While reset is asserted, `cand_ready` is low.
- R2: Out of reset, `cand_ready` is high in any cycle where `upd_valid` is low and low in any cycle where `upd_valid` is high. A candidate offered while `cand_ready` is low is not consumed and produces no pulse.
- R3: An accepted candidate whose bitmap has at least RETIRE_TH (160) set bits causes `retire_valid` with `retire_id` equal to its page number one cycle after acceptance, and it is not held. A count of 159 is not retired.
- R4: An accepted candidate whose bitmap has any set bit in common with a held member causes `rej_valid` with `rej_id` one cycle later, and the held members are unchanged.
- R5: Three mutually disjoint candidates, each with at most SHRINK_TH (80) set bits, form a group. `form_valid` pulses with `form_size` = 3 one cycle after the third is accepted, and `form_id0`, `form_id1` and `form_id2` hold the pages in arrival order.
- R6: If any member (held or arriving) has more than 80 and fewer than 160 set bits, the group closes at two members with `form_size` = 2, and `form_id1` is the arriving page. A page with exactly 80 set bits counts as light.
- R7: When two light pages are held, a compatible candidate with more than 80 set bits is rejected, and the two held pages stay held.
- R8: A wear update (`upd_valid`) whose bitmap has at least 160 set bits causes `retire_valid` with `retire_id` = `upd_id` one cycle later.
- R9: A wear update with `upd_in_triple` high and a bit count from 81 to 159 causes `disband_valid` with `disband_id` = `upd_id` one cycle later. With `upd_in_triple` low, or with a count of 80 or less, no pulse appears.
- R10: At most one event pulse is high in any cycle, and every pulse lasts exactly one cycle unless a new accepted input causes another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 1 | Candidate page offered |
| cand_ready | output | 1 | Candidate can be accepted this cycle |
| cand_id | input | ID_W | Candidate page number |
| cand_map | input | MAP_W | Candidate failed-bit bitmap |
| upd_valid | input | 1 | Wear update for a grouped page |
| upd_id | input | ID_W | Updated page number |
| upd_map | input | MAP_W | Updated failed-bit bitmap |
| upd_in_triple | input | 1 | Updated page belongs to a three-page group |
| form_valid | output | 1 | Group formed pulse |
| form_size | output | 2 | Members in the formed group (2 or 3) |
| form_id0 | output | ID_W | First member |
| form_id1 | output | ID_W | Second member |
| form_id2 | output | ID_W | Third member (zero for a pair) |
| retire_valid | output | 1 | Page retirement pulse |
| retire_id | output | ID_W | Retired page number |
| rej_valid | output | 1 | Candidate rejected pulse |
| rej_id | output | ID_W | Rejected page number |
| disband_valid | output | 1 | Break-up request pulse |
| disband_id | output | ID_W | Page whose three-page group must be split |

## Verification
Some properties are checked by the assertions on every cycle. At most one event pulse is high at a time, and a wear update always blocks the candidate handshake. Every form, reject or retire pulse follows an accepted input of the right kind. A disband pulse carries the page number of the triple-flagged update one cycle earlier, and a formed group is always two or three pages. The bench scenarios must show the rest: whether the right pages are grouped and in what order, whether the 80/81 and 159/160 boundaries fall on the correct side, and whether a rejection leaves the held members intact. These depend on bitmap content and on the history of earlier accepts.

// File: rtl/pg_pkg.sv
// Package: shared types for the worn page grouping controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pg_pkg;

    // Outcome of an accepted candidate
    typedef enum logic [1:0] {
        VERDICT_HOLD   = 2'd0,
        VERDICT_FORM   = 2'd1,
        VERDICT_RETIRE = 2'd2,
        VERDICT_REJECT = 2'd3
    } verdict_e;

    // Outcome of a wear update
    typedef enum logic [1:0] {
        WEAR_QUIET   = 2'd0,
        WEAR_DISBAND = 2'd1,
        WEAR_RETIRE  = 2'd2
    } wear_e;

endpackage

// File: rtl/pg_popcount.sv
// Module: pg_popcount
// Counts the set bits of a failed-bit bitmap, combinationally.
// Assumes: CW is wide enough to hold W.
module pg_popcount #(
    parameter int W  = 256,
    parameter int CW = 9
) (
    input  logic [W-1:0]  map,
    output logic [CW-1:0] count
);

    // Sum the bitmap one bit at a time (the tool builds an adder tree)
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(map[i]);
        end
    end

endmodule

// File: rtl/pg_overlap.sv
// Module: pg_overlap
// Flags, for each occupied hold slot, whether the candidate bitmap shares
// a failed position with that slot's bitmap.
// Assumes: slot_used marks which slots are occupied.
module pg_overlap #(
    parameter int W     = 256,
    parameter int SLOTS = 2
) (
    input  logic [W-1:0]            cand_map,
    input  logic [SLOTS-1:0][W-1:0] slot_map,
    input  logic [SLOTS-1:0]        slot_used,
    output logic [SLOTS-1:0]        clash
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // AND the two bitmaps, OR-reduce, and qualify with occupancy
        always_comb begin
            clash[s] = slot_used[s] & (|(cand_map & slot_map[s]));
        end
    end

endmodule

// File: rtl/pg_wear_class.sv
// Module: pg_wear_class
// Classifies a failed-bit count against the shrink and retirement limits.
// Assumes: SHRINK_TH < RETIRE_TH and both fit in CW bits.
module pg_wear_class #(
    parameter int CW        = 9,
    parameter int SHRINK_TH = 80,
    parameter int RETIRE_TH = 160
) (
    input  logic [CW-1:0] count,
    output logic          heavy,
    output logic          worn_out
);

    // Strictly above the shrink limit is heavy; at or above retire is worn out
    always_comb begin
        heavy    = count > CW'(SHRINK_TH);
        worn_out = count >= CW'(RETIRE_TH);
    end

endmodule

// File: rtl/pg_group_ctrl.sv
// Module: pg_group_ctrl (top)
// Accepts worn pages one at a time and builds parity groups of three
// mutually disjoint pages, or of two when any member is heavily worn.
// Retires pages past the failure limit and requests a break-up of a
// three-page group when a wear update shows one member became heavy.
// Assumes: at most one input event per cycle (an update blocks the
// candidate handshake); all outputs are registered one-cycle pulses.
module pg_group_ctrl
    import pg_pkg::*;
#(
    parameter int ID_W      = 12,
    parameter int MAP_W     = 256,
    parameter int SHRINK_TH = 80,
    parameter int RETIRE_TH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_valid,
    output logic             cand_ready,
    input  logic [ID_W-1:0]  cand_id,
    input  logic [MAP_W-1:0] cand_map,
    input  logic             upd_valid,
    input  logic [ID_W-1:0]  upd_id,
    input  logic [MAP_W-1:0] upd_map,
    input  logic             upd_in_triple,
    output logic             form_valid,
    output logic [1:0]       form_size,
    output logic [ID_W-1:0]  form_id0,
    output logic [ID_W-1:0]  form_id1,
    output logic [ID_W-1:0]  form_id2,
    output logic             retire_valid,
    output logic [ID_W-1:0]  retire_id,
    output logic             rej_valid,
    output logic [ID_W-1:0]  rej_id,
    output logic             disband_valid,
    output logic [ID_W-1:0]  disband_id
);

    localparam int CNT_W   = $clog2(MAP_W + 1);
    localparam int MAX_GRP = 3;
    localparam int HOLD    = MAX_GRP - 1;
    localparam int HELD_W  = $clog2(HOLD + 1);

    // Hold slots for the partial group
    logic [HOLD-1:0][MAP_W-1:0] slot_map_q;
    logic [HOLD-1:0][ID_W-1:0]  slot_id_q;
    logic [HOLD-1:0]            slot_heavy_q;
    logic [HELD_W-1:0]          held_q;
    logic [HOLD-1:0]            slot_used;
    logic [HOLD-1:0]            clash;
    logic                       ready_q;

    logic [CNT_W-1:0] cand_cnt;
    logic [CNT_W-1:0] upd_cnt;
    logic             cand_heavy;
    logic             cand_worn;
    logic             upd_heavy;
    logic             upd_worn;

    logic             accept;
    logic             group_heavy;
    logic [1:0]       target_size;
    logic [1:0]       next_size;
    verdict_e         verdict;
    wear_e            wear;

    // ---------------------------------------------------------------
    // Fault counting and classification
    // ---------------------------------------------------------------
    pg_popcount #(.W(MAP_W), .CW(CNT_W)) u_cnt_cand (
        .map   (cand_map),
        .count (cand_cnt)
    );

    pg_popcount #(.W(MAP_W), .CW(CNT_W)) u_cnt_upd (
        .map   (upd_map),
        .count (upd_cnt)
    );

    pg_wear_class #(.CW(CNT_W), .SHRINK_TH(SHRINK_TH), .RETIRE_TH(RETIRE_TH)) u_cls_cand (
        .count    (cand_cnt),
        .heavy    (cand_heavy),
        .worn_out (cand_worn)
    );

    pg_wear_class #(.CW(CNT_W), .SHRINK_TH(SHRINK_TH), .RETIRE_TH(RETIRE_TH)) u_cls_upd (
        .count    (upd_cnt),
        .heavy    (upd_heavy),
        .worn_out (upd_worn)
    );

    // ---------------------------------------------------------------
    // Overlap check against the held members
    // ---------------------------------------------------------------
    for (genvar s = 0; s < HOLD; s++) begin : g_used
        // A slot is occupied when its index is below the held count
        always_comb begin
            slot_used[s] = held_q > HELD_W'(s);
        end
    end

    pg_overlap #(.W(MAP_W), .SLOTS(HOLD)) u_overlap (
        .cand_map  (cand_map),
        .slot_map  (slot_map_q),
        .slot_used (slot_used),
        .clash     (clash)
    );

    // ---------------------------------------------------------------
    // Handshake: updates take priority over candidates
    // ---------------------------------------------------------------
    // Ready rises one cycle after reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Candidate port yields to any wear update in the same cycle
    always_comb begin
        cand_ready = ready_q & ~upd_valid;
        accept     = cand_valid & cand_ready;
    end

    // ---------------------------------------------------------------
    // Candidate decision
    // ---------------------------------------------------------------
    // Decide the fate of the offered candidate
    always_comb begin
        group_heavy = (|(slot_heavy_q & slot_used)) | cand_heavy;
        target_size = group_heavy ? 2'd2 : 2'(MAX_GRP);
        next_size   = 2'(held_q) + 2'd1;
        if (cand_worn) begin
            verdict = VERDICT_RETIRE;
        end else if (|clash) begin
            verdict = VERDICT_REJECT;
        end else if ((held_q == HELD_W'(HOLD)) && cand_heavy) begin
            verdict = VERDICT_REJECT;
        end else if (next_size >= target_size) begin
            verdict = VERDICT_FORM;
        end else begin
            verdict = VERDICT_HOLD;
        end
    end

    // Classify a wear update on an already grouped page
    always_comb begin
        if (!upd_valid)                     wear = WEAR_QUIET;
        else if (upd_worn)                  wear = WEAR_RETIRE;
        else if (upd_in_triple && upd_heavy) wear = WEAR_DISBAND;
        else                                wear = WEAR_QUIET;
    end

    // ---------------------------------------------------------------
    // Hold slot state
    // ---------------------------------------------------------------
    // Store a held candidate or clear the slots when a group closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q       <= '0;
            slot_map_q   <= '0;
            slot_id_q    <= '0;
            slot_heavy_q <= '0;
        end else if (accept) begin
            case (verdict)
                VERDICT_HOLD: begin
                    slot_map_q[held_q[0]]   <= cand_map;
                    slot_id_q[held_q[0]]    <= cand_id;
                    slot_heavy_q[held_q[0]] <= cand_heavy;
                    held_q                  <= held_q + HELD_W'(1);
                end
                VERDICT_FORM: begin
                    held_q <= '0;
                end
                default: begin
                    held_q <= held_q;
                end
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Event outputs
    // ---------------------------------------------------------------
    // Register one-cycle event pulses and their page numbers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            form_valid    <= 1'b0;
            form_size     <= '0;
            form_id0      <= '0;
            form_id1      <= '0;
            form_id2      <= '0;
            retire_valid  <= 1'b0;
            retire_id     <= '0;
            rej_valid     <= 1'b0;
            rej_id        <= '0;
            disband_valid <= 1'b0;
            disband_id    <= '0;
        end else begin
            form_valid    <= 1'b0;
            retire_valid  <= 1'b0;
            rej_valid     <= 1'b0;
            disband_valid <= 1'b0;
            if (accept) begin
                case (verdict)
                    VERDICT_FORM: begin
                        form_valid <= 1'b1;
                        form_size  <= next_size;
                        form_id0   <= slot_id_q[0];
                        form_id1   <= (held_q == HELD_W'(HOLD)) ? slot_id_q[1] : cand_id;
                        form_id2   <= (held_q == HELD_W'(HOLD)) ? cand_id : '0;
                    end
                    VERDICT_RETIRE: begin
                        retire_valid <= 1'b1;
                        retire_id    <= cand_id;
                    end
                    VERDICT_REJECT: begin
                        rej_valid <= 1'b1;
                        rej_id    <= cand_id;
                    end
                    default: begin
                        form_valid <= 1'b0;
                    end
                endcase
            end
            case (wear)
                WEAR_RETIRE: begin
                    retire_valid <= 1'b1;
                    retire_id    <= upd_id;
                end
                WEAR_DISBAND: begin
                    disband_valid <= 1'b1;
                    disband_id    <= upd_id;
                end
                default: begin
                    disband_valid <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pg_group_ctrl_chk.sv
// Module: pg_group_ctrl_chk
// Cycle-by-cycle protocol checks for pg_group_ctrl, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module pg_group_ctrl_chk #(
    parameter int ID_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cand_valid,
    input logic            cand_ready,
    input logic            upd_valid,
    input logic [ID_W-1:0] upd_id,
    input logic            upd_in_triple,
    input logic            form_valid,
    input logic [1:0]      form_size,
    input logic            retire_valid,
    input logic            rej_valid,
    input logic            disband_valid,
    input logic [ID_W-1:0] disband_id
);

    assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({form_valid, retire_valid, rej_valid, disband_valid}));

    assert_update_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !cand_ready);

    assert_form_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        form_valid |-> (form_size == 2'd2 || form_size == 2'd3));

    assert_form_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        form_valid |-> $past(cand_valid && cand_ready));

    assert_reject_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> $past(cand_valid && cand_ready));

    assert_retire_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> $past(upd_valid || (cand_valid && cand_ready)));

    assert_disband_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disband_valid |-> ($past(upd_valid && upd_in_triple) && disband_id == $past(upd_id)));

endmodule

bind pg_group_ctrl pg_group_ctrl_chk #(.ID_W(ID_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cand_valid    (cand_valid),
    .cand_ready    (cand_ready),
    .upd_valid     (upd_valid),
    .upd_id        (upd_id),
    .upd_in_triple (upd_in_triple),
    .form_valid    (form_valid),
    .form_size     (form_size),
    .retire_valid  (retire_valid),
    .rej_valid     (rej_valid),
    .disband_valid (disband_valid),
    .disband_id    (disband_id)
);

// File: tb/pg_group_ctrl_tb.sv
// Bench for pg_group_ctrl: directed threshold and overlap cases followed by
// seeded random traffic, checked against a behavioural model of the rules.
module pg_group_ctrl_tb;

    localparam int ID_W  = 12;
    localparam int MAP_W = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cand_valid = 1'b0;
    logic             cand_ready;
    logic [ID_W-1:0]  cand_id = '0;
    logic [MAP_W-1:0] cand_map = '0;
    logic             upd_valid = 1'b0;
    logic [ID_W-1:0]  upd_id = '0;
    logic [MAP_W-1:0] upd_map = '0;
    logic             upd_in_triple = 1'b0;
    logic             form_valid;
    logic [1:0]       form_size;
    logic [ID_W-1:0]  form_id0, form_id1, form_id2;
    logic             retire_valid;
    logic [ID_W-1:0]  retire_id;
    logic             rej_valid;
    logic [ID_W-1:0]  rej_id;
    logic             disband_valid;
    logic [ID_W-1:0]  disband_id;

    int n_cmp = 0;
    int n_bad = 0;
    logic [ID_W-1:0] next_id = 12'd1;

    // Model state and expectations
    int              m_held = 0;
    logic [ID_W-1:0] m_id [2];
    logic [MAP_W-1:0] m_map [2];
    bit              m_heavy [2];
    bit              e_form, e_ret, e_rej, e_dis;
    logic [1:0]      e_size;
    logic [ID_W-1:0] e_id0, e_id1, e_id2, e_retid, e_rejid, e_disid;
    string           e_tag;

    always #2.5 clk = ~clk;

    pg_group_ctrl #(.ID_W(ID_W), .MAP_W(MAP_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cand_valid(cand_valid), .cand_ready(cand_ready),
        .cand_id(cand_id), .cand_map(cand_map),
        .upd_valid(upd_valid), .upd_id(upd_id), .upd_map(upd_map),
        .upd_in_triple(upd_in_triple),
        .form_valid(form_valid), .form_size(form_size),
        .form_id0(form_id0), .form_id1(form_id1), .form_id2(form_id2),
        .retire_valid(retire_valid), .retire_id(retire_id),
        .rej_valid(rej_valid), .rej_id(rej_id),
        .disband_valid(disband_valid), .disband_id(disband_id)
    );

    function automatic int pop(input logic [MAP_W-1:0] m);
        int c = 0;
        for (int i = 0; i < MAP_W; i++) c += int'(m[i]);
        return c;
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Map with k failed bits drawn from [lo, lo+w)
    task automatic gen_map(input int k, input int lo, input int w,
                           output logic [MAP_W-1:0] m);
        m = '0;
        while (pop(m) < k) m[lo + int'($urandom % w)] = 1'b1;
    endtask

    // Map with exactly k failed bits from bit position lo upward
    function automatic logic [MAP_W-1:0] run_map(input int lo, input int k);
        logic [MAP_W-1:0] m = '0;
        for (int i = 0; i < k; i++) m[lo + i] = 1'b1;
        return m;
    endfunction

    function automatic void clear_exp();
        e_form = 0; e_ret = 0; e_rej = 0; e_dis = 0; e_size = 0;
        e_id0 = 0; e_id1 = 0; e_id2 = 0; e_retid = 0; e_rejid = 0; e_disid = 0;
        e_tag = "R10";
    endfunction

    // Reference rules for an accepted candidate
    function automatic void model_cand(input logic [ID_W-1:0] id, input logic [MAP_W-1:0] mp);
        int c = pop(mp);
        bit hv = (c > 80);
        bit clash = 0;
        bit gh = hv;
        clear_exp();
        if (c >= 160) begin
            e_ret = 1; e_retid = id; e_tag = "R3";
            return;
        end
        for (int i = 0; i < m_held; i++) begin
            if ((mp & m_map[i]) != '0) clash = 1;
            gh |= m_heavy[i];
        end
        if (clash) begin
            e_rej = 1; e_rejid = id; e_tag = "R4";
        end else if (m_held == 2 && hv) begin
            e_rej = 1; e_rejid = id; e_tag = "R7";
        end else if (m_held + 1 >= (gh ? 2 : 3)) begin
            e_form = 1; e_size = 2'(m_held + 1);
            e_id0 = m_id[0];
            e_id1 = (m_held == 2) ? m_id[1] : id;
            e_id2 = (m_held == 2) ? id : '0;
            e_tag = (m_held == 2) ? "R5" : "R6";
            m_held = 0;
        end else begin
            m_id[m_held] = id; m_map[m_held] = mp; m_heavy[m_held] = hv;
            m_held++;
            e_tag = "R5";
        end
    endfunction

    // Reference rules for a wear update
    function automatic void model_upd(input logic [ID_W-1:0] id, input logic [MAP_W-1:0] mp,
                                      input bit tri3);
        int c = pop(mp);
        clear_exp();
        if (c >= 160) begin
            e_ret = 1; e_retid = id; e_tag = "R8";
        end else if (tri3 && c > 80) begin
            e_dis = 1; e_disid = id; e_tag = "R9";
        end else begin
            e_tag = "R9";
        end
    endfunction

    task automatic check_outputs();
        cmp(e_tag, "form_valid", 32'(form_valid), 32'(e_form));
        cmp(e_tag, "retire_valid", 32'(retire_valid), 32'(e_ret));
        cmp(e_tag, "rej_valid", 32'(rej_valid), 32'(e_rej));
        cmp(e_tag, "disband_valid", 32'(disband_valid), 32'(e_dis));
        if (e_form) begin
            cmp(e_tag, "form_size", 32'(form_size), 32'(e_size));
            cmp(e_tag, "form_id0", 32'(form_id0), 32'(e_id0));
            cmp(e_tag, "form_id1", 32'(form_id1), 32'(e_id1));
            cmp(e_tag, "form_id2", 32'(form_id2), 32'(e_id2));
        end
        if (e_ret) cmp(e_tag, "retire_id", 32'(retire_id), 32'(e_retid));
        if (e_rej) cmp(e_tag, "rej_id", 32'(rej_id), 32'(e_rejid));
        if (e_dis) cmp(e_tag, "disband_id", 32'(disband_id), 32'(e_disid));
    endtask

    // One candidate step; entered and left just after a falling edge
    task automatic do_cand(input logic [MAP_W-1:0] mp);
        logic [ID_W-1:0] id = next_id;
        next_id++;
        cand_valid = 1; cand_id = id; cand_map = mp;
        #1 cmp("R2", "cand_ready idle", 32'(cand_ready), 32'd1);
        model_cand(id, mp);
        @(posedge clk); @(negedge clk);
        cand_valid = 0;
        check_outputs();
    endtask

    // One wear update, optionally with a competing candidate
    task automatic do_upd(input logic [MAP_W-1:0] mp, input bit tri3, input bit race);
        logic [ID_W-1:0] id = next_id;
        next_id++;
        upd_valid = 1; upd_id = id; upd_map = mp; upd_in_triple = tri3;
        cand_valid = race; cand_id = 12'hFFF; cand_map = run_map(0, 170);
        #1 cmp("R2", "cand_ready during update", 32'(cand_ready), 32'd0);
        model_upd(id, mp, tri3);
        @(posedge clk); @(negedge clk);
        upd_valid = 0; cand_valid = 0;
        check_outputs();
    endtask

    task automatic do_idle();
        clear_exp();
        @(posedge clk); @(negedge clk);
        check_outputs();
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [MAP_W-1:0] mp;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        cmp("R1", "cand_ready in reset", 32'(cand_ready), 32'd0);
        rst_n = 1;
        @(negedge clk);
        clear_exp(); e_tag = "R1";
        check_outputs();

        // R5: three disjoint light pages after reset form a triple
        do_cand(run_map(0, 10));
        do_cand(run_map(20, 10));
        do_cand(run_map(40, 10));
        do_idle(); // R10: pulse lasts one cycle

        // R4: overlap rejected, held member kept, then triple completes
        do_cand(run_map(0, 8));
        do_cand(run_map(7, 4));
        do_cand(run_map(30, 4));
        do_cand(run_map(60, 4));

        // R6: light then heavy (81) closes a pair; exactly 80 stays light
        do_cand(run_map(0, 5));
        do_cand(run_map(10, 81));
        do_cand(run_map(0, 80));
        do_cand(run_map(90, 5));
        do_cand(run_map(100, 5));

        // R7: heavy candidate rejected when two light pages held
        do_cand(run_map(0, 3));
        do_cand(run_map(5, 3));
        do_cand(run_map(20, 90));
        do_cand(run_map(10, 3));

        // R3: 159 is held (heavy), 160 retired, then pair completes
        do_cand(run_map(0, 159));
        do_cand(run_map(0, 160));
        do_cand(run_map(200, 2));

        // R8 / R9 wear updates, with and without a racing candidate
        do_upd(run_map(0, 160), 1'b0, 1'b1);
        do_upd(run_map(0, 81), 1'b1, 1'b0);
        do_upd(run_map(0, 81), 1'b0, 1'b1);
        do_upd(run_map(0, 80), 1'b1, 1'b0);
        do_upd(run_map(0, 159), 1'b1, 1'b1);
        do_idle();

        // Random traffic
        for (int s = 0; s < 800; s++) begin
            int r = int'($urandom % 100);
            if (r < 8) begin
                do_idle();
            end else if (r < 22) begin
                gen_map(60 + int'($urandom % 111), 0, MAP_W, mp);
                do_upd(mp, 1'($urandom % 2), 1'($urandom % 2));
            end else if (r < 62) begin
                gen_map(int'($urandom % 6), int'($urandom % 192), 64, mp);
                do_cand(mp);
            end else if (r < 80) begin
                gen_map(70 + int'($urandom % 20), 0, MAP_W, mp);
                do_cand(mp);
            end else if (r < 90) begin
                gen_map(150 + int'($urandom % 20), 0, MAP_W, mp);
                do_cand(mp);
            end else begin
                gen_map(int'($urandom % 30), 0, MAP_W, mp);
                do_cand(mp);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule